// File: doc/BRIEF.md
# Sector Write-Protect and Acceleration Gate

This block decides, one request at a time, whether a program or erase aimed at a flash word address may go ahead. It maps the word address onto an uneven sector map and looks up a stored lock bit for that sector. It then applies a three-level write-protect input that can override the stored bit. The answer is a one-cycle pulse: a program go, an erase go, or a deny. A deny opens a short busy window. During that window the block takes no new request and the array is left untouched, so the caller simply falls back to reading.

The lock bits are changed by in-system operations. A protect operation locks the sector that holds a given address. An unprotect operation clears every lock at once. The lock bits are not cleared by the hardware reset. The protect input arrives as a 2-bit level code. The high-voltage level temporarily unprotects everything, forces the command layer into its two-cycle unlock-bypass program mode and selects the shortened program timing (about 40 percent faster). When that level goes away, the stored locks and normal command mode apply again.

Top module: `sector_guard`

## Requirements
- R1: Sectors are picked by address bits 21..12. When bits 21..15 are all zero, the sector is bits 14..12 (sectors 0–7, 4 Kwords each). When bits 21..15 are all ones, the sector is 134 plus bits 14..12 (sectors 134–141, 4 Kwords each). Any other value v of bits 21..15 selects sector v+7, a 32 Kword sector.
- R2: A request taken in one cycle is answered in the next cycle. An unlocked sector gives go_program (req_erase=0) or go_erase (req_erase=1). A locked sector gives deny, whether the request is a program or an erase. At most one of the three pulses is high.
- R3: With wp_lvl=00 (low), any request to sectors 0, 1, 140 or 141 is denied, whatever their stored bits say.
- R4: With wp_lvl=01 (high), or the code 11 (treated as high), every sector, boot sectors included, follows its stored lock bit.
- R5: With wp_lvl=10 (high voltage), every request is granted. The stored lock bits stay as they were and apply again once the level drops.
- R6: bypass_forced and accel are high in the cycle after a clock edge that sampled wp_lvl=10, and low in the cycle after an edge that sampled any other code.
- R7: A deny raises busy for exactly BUSY_CYC cycles, counting the cycle of the deny pulse. A request presented while busy is high is dropped and produces no pulse.
- R8: prot_valid with prot_set=1 locks the sector that holds prot_addr. prot_valid with prot_set=0 clears all locks. prot_status shows the stored lock bit of the sector addressed by req_addr as it was at the previous clock edge.
- R9: Asserting rst_n low does not change any stored lock bit.
- R10: While reset is held, go_program, go_erase, deny, busy, bypass_forced, accel and prot_status are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wp_lvl | input | 2 | Protect level: 00 low, 01 high, 10 high voltage, 11 as high |
| req_valid | input | 1 | Program or erase request strobe |
| req_erase | input | 1 | 1 for an erase request, 0 for a program request |
| req_addr | input | 22 | Word address of the request; also selects the sector shown on prot_status |
| prot_valid | input | 1 | Protection operation strobe |
| prot_set | input | 1 | 1 locks the addressed sector, 0 clears all locks |
| prot_addr | input | 22 | Word address of the sector to lock |
| go_program | output | 1 | Program permitted (one-cycle pulse) |
| go_erase | output | 1 | Erase permitted (one-cycle pulse) |
| deny | output | 1 | Request rejected (one-cycle pulse) |
| busy | output | 1 | Rejection window in progress; requests are dropped |
| bypass_forced | output | 1 | Unlock-bypass command mode forced by the high-voltage level |
| accel | output | 1 | Shortened program timing selected |
| prot_status | output | 1 | Stored lock bit of the sector at req_addr |

## Verification
A wrong sector decode or a lost lock bit shows up on the very next request to an affected sector. It appears as a go pulse where a deny is due, or the other way round. The same error shows on prot_status one cycle after req_addr points at that sector. A wrong level override shows only for the boot sectors or under the high-voltage code, so the stimulus hits each boundary sector under every level code. A counter that sticks or ends early changes the length of busy after a deny, and it can also swallow or let through a request sent inside the window. Both are visible within BUSY_CYC cycles.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_HIGH = 2'b01,
    LVL_HV   = 2'b10,
    LVL_ALT  = 2'b11
  } wp_level_e;

  typedef struct packed {
    logic boot_lock;  // outermost sectors forced locked
    logic all_open;   // every lock ignored, bypass and fast timing
  } lvl_ctl_t;
endpackage

// File: rtl/sg_sector_decode.sv
module sg_sector_decode #(
  parameter int ADDR_W      = 22,
  parameter int SMALL_SHIFT = 12,
  parameter int BIG_SHIFT   = 15,
  parameter int N_SECT      = 142,
  parameter int SECT_W      = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SECT_W-1:0] idx
);
  localparam int BLK_W = ADDR_W - BIG_SHIFT;
  localparam int SUB_W = BIG_SHIFT - SMALL_SHIFT;
  localparam int SUB_N = 1 << SUB_W;

  logic [BLK_W-1:0] blk;
  logic [SUB_W-1:0] sub;

  assign blk = addr[ADDR_W-1:BIG_SHIFT];
  assign sub = addr[BIG_SHIFT-1:SMALL_SHIFT];

  always_comb begin
    if (blk == '0) begin
      idx = SECT_W'(sub);
    end else if (blk == {BLK_W{1'b1}}) begin
      idx = SECT_W'(N_SECT - SUB_N) + SECT_W'(sub);
    end else begin
      idx = SECT_W'(blk) + SECT_W'(SUB_N - 1);
    end
  end
endmodule

// File: rtl/sg_level_decode.sv
module sg_level_decode
  import sg_pkg::*;
(
  input  logic [1:0] lvl_code,
  output lvl_ctl_t   ctl
);
  wp_level_e lvl;
  assign lvl = wp_level_e'(lvl_code);

  always_comb begin
    ctl = '0;
    unique case (lvl)
      LVL_LOW:  ctl.boot_lock = 1'b1;
      LVL_HV:   ctl.all_open  = 1'b1;
      LVL_HIGH,
      LVL_ALT:  ctl = '0;
      default:  ctl = '0;
    endcase
  end
endmodule

// File: rtl/sg_lock_store.sv
module sg_lock_store #(
  parameter int N_SECT = 142,
  parameter int SECT_W = 8
) (
  input  logic              clk,
  input  logic              set_en,
  input  logic [SECT_W-1:0] set_idx,
  input  logic              clr_all,
  input  logic [SECT_W-1:0] rd_idx,
  output logic              rd_bit
);
  logic [N_SECT-1:0] lock_vec;

  // No reset on purpose: locks persist across the hardware reset.
  generate
    for (genvar i = 0; i < N_SECT; i++) begin : g_lock
      logic hit;
      logic bit_q;
      assign hit = set_en && (set_idx == SECT_W'(i));
      always_ff @(posedge clk) begin
        if (clr_all) begin
          bit_q <= 1'b0;
        end else if (hit) begin
          bit_q <= 1'b1;
        end
      end
      assign lock_vec[i] = bit_q;
    end
  endgenerate

  always_comb begin
    rd_bit = 1'b0;
    for (int i = 0; i < N_SECT; i++) begin
      if (rd_idx == SECT_W'(i)) rd_bit = lock_vec[i];
    end
  end
endmodule

// File: rtl/sector_guard.sv
module sector_guard
  import sg_pkg::*;
#(
  parameter int ADDR_W      = 22,
  parameter int SMALL_SHIFT = 12,
  parameter int BIG_SHIFT   = 15,
  parameter int N_SECT      = 142,
  parameter int BUSY_CYC    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        wp_lvl,
  input  logic              req_valid,
  input  logic              req_erase,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              prot_valid,
  input  logic              prot_set,
  input  logic [ADDR_W-1:0] prot_addr,
  output logic              go_program,
  output logic              go_erase,
  output logic              deny,
  output logic              busy,
  output logic              bypass_forced,
  output logic              accel,
  output logic              prot_status
);
  localparam int SECT_W = $clog2(N_SECT);
  localparam int CNT_W  = $clog2(BUSY_CYC + 1);

  logic [SECT_W-1:0] req_idx;
  logic [SECT_W-1:0] prot_idx;
  logic              stored_lock;
  logic              req_boot;
  logic              eff_lock;
  logic              accept;
  lvl_ctl_t          lvl_ctl;

  logic              go_prog_d, go_prog_q;
  logic              go_era_d,  go_era_q;
  logic              deny_d,    deny_q;
  logic              hv_d,      hv_q;
  logic              stat_d,    stat_q;
  logic [CNT_W-1:0]  cnt_d,     cnt_q;

  sg_sector_decode #(
    .ADDR_W(ADDR_W), .SMALL_SHIFT(SMALL_SHIFT), .BIG_SHIFT(BIG_SHIFT),
    .N_SECT(N_SECT), .SECT_W(SECT_W)
  ) u_req_dec (
    .addr (req_addr),
    .idx  (req_idx)
  );

  sg_sector_decode #(
    .ADDR_W(ADDR_W), .SMALL_SHIFT(SMALL_SHIFT), .BIG_SHIFT(BIG_SHIFT),
    .N_SECT(N_SECT), .SECT_W(SECT_W)
  ) u_prot_dec (
    .addr (prot_addr),
    .idx  (prot_idx)
  );

  sg_level_decode u_lvl (
    .lvl_code (wp_lvl),
    .ctl      (lvl_ctl)
  );

  sg_lock_store #(.N_SECT(N_SECT), .SECT_W(SECT_W)) u_store (
    .clk     (clk),
    .set_en  (prot_valid && prot_set),
    .set_idx (prot_idx),
    .clr_all (prot_valid && !prot_set),
    .rd_idx  (req_idx),
    .rd_bit  (stored_lock)
  );

  // Outermost two sectors on each end of the map
  assign req_boot = (req_idx == SECT_W'(0)) || (req_idx == SECT_W'(1)) ||
                    (req_idx == SECT_W'(N_SECT - 2)) ||
                    (req_idx == SECT_W'(N_SECT - 1));

  always_comb begin
    if (lvl_ctl.all_open) begin
      eff_lock = 1'b0;
    end else if (lvl_ctl.boot_lock && req_boot) begin
      eff_lock = 1'b1;
    end else begin
      eff_lock = stored_lock;
    end
  end

  // Next-state
  always_comb begin
    accept    = req_valid && (cnt_q == '0);
    go_prog_d = accept && !eff_lock && !req_erase;
    go_era_d  = accept && !eff_lock &&  req_erase;
    deny_d    = accept &&  eff_lock;
    hv_d      = lvl_ctl.all_open;
    stat_d    = stored_lock;
    if (deny_d) begin
      cnt_d = CNT_W'(BUSY_CYC);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end else begin
      cnt_d = cnt_q;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_prog_q <= 1'b0;
      go_era_q  <= 1'b0;
      deny_q    <= 1'b0;
      hv_q      <= 1'b0;
      stat_q    <= 1'b0;
      cnt_q     <= '0;
    end else begin
      go_prog_q <= go_prog_d;
      go_era_q  <= go_era_d;
      deny_q    <= deny_d;
      hv_q      <= hv_d;
      stat_q    <= stat_d;
      cnt_q     <= cnt_d;
    end
  end

  assign go_program    = go_prog_q;
  assign go_erase      = go_era_q;
  assign deny          = deny_q;
  assign busy          = (cnt_q != '0);
  assign bypass_forced = hv_q;
  assign accel         = hv_q;
  assign prot_status   = stat_q;
endmodule

// File: rtl/sector_guard_chk.sv
module sector_guard_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  wp_lvl,
  input logic        req_valid,
  input logic [21:0] req_addr,
  input logic        go_program,
  input logic        go_erase,
  input logic        deny,
  input logic        busy,
  input logic        bypass_forced
);
  AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({go_program, go_erase, deny}) <= 1);  // R2

  AST_LOW_BOOT_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && wp_lvl == 2'b00 && req_addr[21:13] == 9'd0)
      |=> deny);  // R3

  AST_HV_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && wp_lvl == 2'b10) |=> (go_program || go_erase));  // R5

  AST_BYPASS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_lvl == 2'b10) |=> bypass_forced);  // R6

  AST_BYPASS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_lvl != 2'b10) |=> !bypass_forced);  // R6

  AST_DENY_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    deny |-> busy);  // R7

  AST_DROP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && busy) |=> !(go_program || go_erase || deny));  // R7
endmodule

bind sector_guard sector_guard_chk u_chk (.*);

// File: tb/sector_guard_test.sv
module sector_guard_test;
  localparam int BUSY = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  wp_lvl;
  logic        req_valid, req_erase;
  logic [21:0] req_addr;
  logic        prot_valid, prot_set;
  logic [21:0] prot_addr;
  logic        go_program, go_erase, deny, busy, bypass_forced, accel, prot_status;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  sector_guard #(.BUSY_CYC(BUSY)) uut (
    .clk(clk), .rst_n(rst_n), .wp_lvl(wp_lvl), .req_valid(req_valid),
    .req_erase(req_erase), .req_addr(req_addr), .prot_valid(prot_valid),
    .prot_set(prot_set), .prot_addr(prot_addr), .go_program(go_program),
    .go_erase(go_erase), .deny(deny), .busy(busy),
    .bypass_forced(bypass_forced), .accel(accel), .prot_status(prot_status)
  );

  // {level, erase, allowed, address}; locked sectors: 0, 7, 8, 70, 141
  localparam logic [25:0] VEC [0:15] = '{
    {2'b01, 1'b0, 1'b0, 22'h000123},  // R4 R2 sector 0 locked
    {2'b01, 1'b1, 1'b1, 22'h001000},  // R4 sector 1 open, erase
    {2'b00, 1'b0, 1'b0, 22'h001000},  // R3 sector 1 forced
    {2'b00, 1'b1, 1'b0, 22'h3FE000},  // R3 sector 140 forced
    {2'b01, 1'b0, 1'b1, 22'h3FE000},  // R4 sector 140 open
    {2'b01, 1'b1, 1'b0, 22'h007FFF},  // R1 R2 sector 7 locked, erase
    {2'b01, 1'b0, 1'b0, 22'h008000},  // R1 sector 8 first word
    {2'b01, 1'b1, 1'b0, 22'h00FFFF},  // R1 sector 8 last word
    {2'b01, 1'b0, 1'b1, 22'h010000},  // R1 sector 9 open
    {2'b10, 1'b1, 1'b1, 22'h000000},  // R5 sector 0 opened
    {2'b10, 1'b0, 1'b1, 22'h3FF000},  // R5 sector 141 opened
    {2'b11, 1'b0, 1'b0, 22'h1F8000},  // R4 code 11, sector 70 locked
    {2'b11, 1'b1, 1'b1, 22'h200000},  // R4 R1 sector 71 open
    {2'b00, 1'b0, 1'b1, 22'h3F7FFF},  // R1 R3 sector 133 not boot
    {2'b00, 1'b1, 1'b1, 22'h3F8000},  // R1 R3 sector 134 not boot
    {2'b00, 1'b0, 1'b0, 22'h3FFFFF}   // R3 sector 141
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic protect(input logic setb, input logic [21:0] a);
    @(negedge clk);
    prot_valid = 1'b1; prot_set = setb; prot_addr = a;
    @(negedge clk);
    prot_valid = 1'b0;
  endtask

  // Issues one request, returns {go_program, go_erase, deny} one cycle later
  task automatic request(input logic [1:0] lvl, input logic er, input logic [21:0] a,
                         output logic [2:0] res);
    @(negedge clk);
    wp_lvl = lvl; req_erase = er; req_addr = a; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    res = {go_program, go_erase, deny};
    wp_lvl = 2'b01;
    repeat (BUSY + 1) @(negedge clk);
  endtask

  task automatic status_of(input logic [21:0] a, output logic s);
    @(negedge clk);
    req_addr = a;
    @(negedge clk);
    s = prot_status;
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [2:0] res;
    logic       s;
    int         n;

    rst_n = 1'b0; wp_lvl = 2'b01; req_valid = 1'b0; req_erase = 1'b0;
    req_addr = '0; prot_valid = 1'b0; prot_set = 1'b0; prot_addr = '0;
    repeat (3) @(negedge clk);
    check("R10 outputs in reset",
          {25'd0, go_program, go_erase, deny, busy, bypass_forced, accel, prot_status}, 32'd0);
    rst_n = 1'b1;

    protect(1'b0, 22'h0);
    protect(1'b1, 22'h000ABC);  // sector 0
    protect(1'b1, 22'h007000);  // sector 7
    protect(1'b1, 22'h00C000);  // sector 8
    protect(1'b1, 22'h1FFFFF);  // sector 70
    protect(1'b1, 22'h3FF800);  // sector 141

    // Vector walk
    for (int i = 0; i < 16; i++) begin
      logic [2:0] exp;
      logic [25:0] v;
      v = VEC[i];
      request(v[25:24], v[23], v[21:0], res);
      if (v[22]) exp = v[23] ? 3'b010 : 3'b100;
      else       exp = 3'b001;
      check($sformatf("R2 vector %0d", i), {29'd0, res}, {29'd0, exp});
    end

    // R8: status view, same sector via another word, and an open neighbour
    status_of(22'h1F8123, s);
    check("R8 status sector 70", {31'd0, s}, 32'd1);
    status_of(22'h200000, s);
    check("R8 status sector 71", {31'd0, s}, 32'd0);
    // R5: high-voltage grants left the stored bit intact
    status_of(22'h000000, s);
    check("R5 sector 0 still stored locked", {31'd0, s}, 32'd1);

    // R6: level to bypass/accel timing
    @(negedge clk); wp_lvl = 2'b10;
    @(negedge clk);
    check("R6 bypass on", {30'd0, bypass_forced, accel}, 32'd3);
    wp_lvl = 2'b01;
    @(negedge clk);
    check("R6 bypass off", {30'd0, bypass_forced, accel}, 32'd0);

    // R7: busy length and dropped request
    @(negedge clk);
    wp_lvl = 2'b01; req_erase = 1'b0; req_addr = 22'h000010; req_valid = 1'b1;
    @(negedge clk);
    check("R7 deny pulse", {31'd0, deny}, 32'd1);
    n = busy ? 1 : 0;
    req_addr = 22'h010000;  // open sector 9, stays requested into the window
    @(negedge clk);
    check("R7 request in window dropped", {29'd0, go_program, go_erase, deny}, 32'd0);
    req_valid = 1'b0;
    if (busy) n++;
    repeat (6) begin
      @(negedge clk);
      if (busy) n++;
    end
    check("R7 busy length", n, BUSY);

    // R9: locks survive reset
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    status_of(22'h1F8000, s);
    check("R9 sector 70 after reset", {31'd0, s}, 32'd1);
    request(2'b01, 1'b1, 22'h000000, res);
    check("R9 sector 0 after reset", {29'd0, res}, 32'd1);

    // R8: unprotect clears every lock
    protect(1'b0, 22'h123456);
    status_of(22'h1F8000, s);
    check("R8 sector 70 cleared", {31'd0, s}, 32'd0);
    request(2'b01, 1'b0, 22'h000000, res);
    check("R8 sector 0 open after clear", {29'd0, res}, 32'd4);
    request(2'b00, 1'b0, 22'h3FF000, res);
    check("R3 low locks open boot sector", {29'd0, res}, 32'd1);
    request(2'b01, 1'b1, 22'h3FF000, res);
    check("R4 high follows open store", {29'd0, res}, 32'd2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule